// File: doc/BRIEF.md
# Host-Firmware Ownership Mailbox

This block is a small register-mapped mailbox through which a host processor and an embedded controller exchange short command messages. Either side must first take ownership of the mailbox. The host claims it by writing its own owner code into the ownership register and reading the register back. The controller claims it through a strobe. A claim only takes effect while nobody owns the mailbox. Writing the "none" code, or pulsing the controller release strobe, frees the mailbox, and the host treats that release as completion of a command.

Each message is one 32-bit word. An 8-bit type sits in the top byte and a 24-bit payload fills the rest, in both directions. The host places a word in the host-to-controller data register. It then sets the interrupt-enable and controller-destination flags in the command register, which raises the controller interrupt. The controller answers by posting a word into the controller-to-host data register. Posting sets the system-management destination flag and raises the host interrupt until the host clears that flag. Responses use type 0x80 for acknowledge and 0x81 for refusal.

A separate interrupt status register holds an enable bit and a firmware-hang flag. The controller sets the hang flag with a strobe, and the host clears it by writing back the value it read.

Top module: `host_fw_mailbox`

## Requirements
- R1: After reset every mapped register reads 0 (owner none) and both `hostIrq` and `ctrlIrq` are low.
- R2: Word address 0 is the ownership register with code 0 = none, 1 = controller, 2 = host. It reads back in bits 1:0 with the upper bits 0. A host write of 1 or 2 while the owner is none sets the owner to that code.
- R3: A host write of 1 or 2 to the ownership register while the owner is not none is ignored. A write of code 3 is always ignored.
- R4: A host write of 0 to the ownership register, or a pulse on `ctrlReleaseEn`, sets the owner to none from any state.
- R5: A pulse on `ctrlClaimEn` sets the owner to 1 only when the owner is none; otherwise the owner is unchanged.
- R6: A host write to word address 1 (host-to-controller data) is read back unchanged. Its bits 31:24 appear on `ctrlInType` and bits 23:0 appear on `ctrlInPayload`.
- R7: Word address 3 is the command register. Only bits 31 (interrupt enable), 30 (host-controller destination), 29 (system-management destination), 28 (power-event destination) and 27 (controller destination) are stored; all other bits read 0. `ctrlIrq` is high exactly when bits 31 and 27 are both set.
- R8: A pulse on `ctrlAckEn` clears command bit 27 and leaves the other bits unchanged.
- R9: A pulse on `ctrlPostEn` loads word address 2 with {`ctrlPostType`, `ctrlPostPayload`} and sets command bit 29. `hostIrq` stays high until the host writes command bit 29 to 0.
- R10: Word address 4 is the interrupt status register. Bit 3 is a read/write enable. Bit 1 is set by `ctrlHangEn` and cleared by a host write with bit 1 set; a write with bit 1 clear leaves it unchanged. `hostIrq` is also high when bits 3 and 1 are both set.
- R11: Host writes to word address 2 have no effect, and word addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Host word address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Combinational read data of the addressed register |
| ctrlClaimEn | input | 1 | Controller ownership claim strobe |
| ctrlReleaseEn | input | 1 | Controller ownership release strobe |
| ctrlPostEn | input | 1 | Controller posts a message to the host |
| ctrlPostType | input | 8 | Type field of the posted message |
| ctrlPostPayload | input | 24 | Payload of the posted message |
| ctrlAckEn | input | 1 | Controller clears its destination flag |
| ctrlHangEn | input | 1 | Controller raises the firmware-hang flag |
| ctrlInType | output | 8 | Type field of the host-to-controller word |
| ctrlInPayload | output | 24 | Payload of the host-to-controller word |
| ctrlIrq | output | 1 | Interrupt toward the controller |
| hostIrq | output | 1 | Interrupt toward the host |

## Verification
The assertions check the ownership rules on every cycle. A claim against a held mailbox leaves the owner unchanged, a release always lands on none, and a controller claim on a free mailbox yields the controller code. The same checks cover the interrupt side: a post always raises the host interrupt and an acknowledge always drops the controller interrupt. The bench scenarios cover everything that depends on data values. That includes the full claim matrix of start owner against written code, packing of the type and payload fields, and the masking of command bits across all flag combinations. It also covers the write-one-to-clear behaviour of the hang flag with the enable bit in each state.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam logic [1:0] OWNER_NONE = 2'd0;
  localparam logic [1:0] OWNER_FW   = 2'd1;
  localparam logic [1:0] OWNER_SW   = 2'd2;
  localparam logic [1:0] OWNER_BAD  = 2'd3;

  // command flag positions, counted down from the word's top bit
  localparam int CMD_FLAG_CNT    = 5;
  localparam int CMD_INTEN_OFS   = 0;  // top bit
  localparam int CMD_HOSTCTL_OFS = 1;
  localparam int CMD_SYSMGT_OFS  = 2;
  localparam int CMD_PWREVT_OFS  = 3;
  localparam int CMD_CTRL_OFS    = 4;

  // interrupt status bit positions
  localparam int INTR_EN_BIT   = 3;
  localparam int INTR_HANG_BIT = 1;

  localparam logic [7:0] RESP_ACK = 8'h80;
  localparam logic [7:0] RESP_NAK = 8'h81;

  typedef struct packed {
    logic       ownerLoad;
    logic [1:0] ownerVal;
    logic       loadDataIn;
    logic       loadCmd;
    logic       loadIntr;
    logic       postOut;
    logic       clrCtrlDest;
    logic       setHang;
  } mbox_strobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int OFS_OWNER  = 0,
  parameter int OFS_DATAIN = 1,
  parameter int OFS_CMD    = 3,
  parameter int OFS_INTR   = 4
) (
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        ownerCode,
  input  logic [1:0]        ownerState,
  input  logic              ctrlClaimEn,
  input  logic              ctrlReleaseEn,
  input  logic              ctrlPostEn,
  input  logic              ctrlAckEn,
  input  logic              ctrlHangEn,
  output mbox_strobe_t      strobe
);

  logic       hostOwnWr;
  logic [1:0] nextOwner;
  logic       ownerTouched;

  assign hostOwnWr = hostWrEn && (hostAddr == ADDR_W'(OFS_OWNER));

  // Arbitration: host write first, then controller release/claim on top.
  always_comb begin
    nextOwner    = ownerState;
    ownerTouched = 1'b0;
    if (hostOwnWr) begin
      if (ownerCode == OWNER_NONE) begin
        nextOwner    = OWNER_NONE;
        ownerTouched = 1'b1;
      end else if (ownerCode != OWNER_BAD && ownerState == OWNER_NONE) begin
        nextOwner    = ownerCode;
        ownerTouched = 1'b1;
      end
    end
    if (ctrlReleaseEn) begin
      nextOwner    = OWNER_NONE;
      ownerTouched = 1'b1;
    end else if (ctrlClaimEn && nextOwner == OWNER_NONE) begin
      nextOwner    = OWNER_FW;
      ownerTouched = 1'b1;
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.ownerLoad   = ownerTouched;
    strobe.ownerVal    = nextOwner;
    strobe.loadDataIn  = hostWrEn && (hostAddr == ADDR_W'(OFS_DATAIN));
    strobe.loadCmd     = hostWrEn && (hostAddr == ADDR_W'(OFS_CMD));
    strobe.loadIntr    = hostWrEn && (hostAddr == ADDR_W'(OFS_INTR));
    strobe.postOut     = ctrlPostEn;
    strobe.clrCtrlDest = ctrlAckEn;
    strobe.setHang     = ctrlHangEn;
  end

endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int TYPE_W      = 8,
  parameter int PAYLOAD_W   = 24,
  parameter int OFS_OWNER   = 0,
  parameter int OFS_DATAIN  = 1,
  parameter int OFS_DATAOUT = 2,
  parameter int OFS_CMD     = 3,
  parameter int OFS_INTR    = 4,
  localparam int DATA_W     = TYPE_W + PAYLOAD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mbox_strobe_t         strobe,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic [TYPE_W-1:0]    postType,
  input  logic [PAYLOAD_W-1:0] postPayload,
  output logic [DATA_W-1:0]    hostRdData,
  output logic [1:0]           ownerState,
  output logic [TYPE_W-1:0]    inType,
  output logic [PAYLOAD_W-1:0] inPayload,
  output logic                 ctrlIrq,
  output logic                 hostIrq
);

  localparam int INTEN_BIT  = DATA_W - 1 - CMD_INTEN_OFS;
  localparam int SYSMGT_BIT = DATA_W - 1 - CMD_SYSMGT_OFS;
  localparam int CTRL_BIT   = DATA_W - 1 - CMD_CTRL_OFS;

  logic [1:0]        ownerQ;
  logic [DATA_W-1:0] dataInQ;
  logic [DATA_W-1:0] dataOutQ;
  logic [DATA_W-1:0] cmdQ;
  logic [DATA_W-1:0] cmdMask;
  logic [DATA_W-1:0] cmdNext;
  logic              intrEnQ;
  logic              hangQ;

  // mask of stored command flags: the top CMD_FLAG_CNT bits
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b >= DATA_W - CMD_FLAG_CNT) begin : g_on
      assign cmdMask[b] = 1'b1;
    end else begin : g_off
      assign cmdMask[b] = 1'b0;
    end
  end

  always_comb begin
    cmdNext = cmdQ;
    if (strobe.loadCmd) cmdNext = hostWrData & cmdMask;
    if (strobe.postOut) cmdNext[SYSMGT_BIT] = 1'b1;
    if (strobe.clrCtrlDest) cmdNext[CTRL_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ   <= OWNER_NONE;
      dataInQ  <= '0;
      dataOutQ <= '0;
      cmdQ     <= '0;
      intrEnQ  <= 1'b0;
      hangQ    <= 1'b0;
    end else begin
      if (strobe.ownerLoad)  ownerQ   <= strobe.ownerVal;
      if (strobe.loadDataIn) dataInQ  <= hostWrData;
      if (strobe.postOut)    dataOutQ <= {postType, postPayload};
      cmdQ <= cmdNext;
      if (strobe.loadIntr) intrEnQ <= hostWrData[INTR_EN_BIT];
      if (strobe.setHang)
        hangQ <= 1'b1;
      else if (strobe.loadIntr && hostWrData[INTR_HANG_BIT])
        hangQ <= 1'b0;
    end
  end

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      ADDR_W'(OFS_OWNER):   hostRdData[1:0] = ownerQ;
      ADDR_W'(OFS_DATAIN):  hostRdData = dataInQ;
      ADDR_W'(OFS_DATAOUT): hostRdData = dataOutQ;
      ADDR_W'(OFS_CMD):     hostRdData = cmdQ;
      ADDR_W'(OFS_INTR): begin
        hostRdData[INTR_EN_BIT]   = intrEnQ;
        hostRdData[INTR_HANG_BIT] = hangQ;
      end
      default: hostRdData = '0;
    endcase
  end

  assign ownerState = ownerQ;
  assign inType     = dataInQ[DATA_W-1:PAYLOAD_W];
  assign inPayload  = dataInQ[PAYLOAD_W-1:0];
  assign ctrlIrq    = cmdQ[INTEN_BIT] & cmdQ[CTRL_BIT];
  assign hostIrq    = cmdQ[SYSMGT_BIT] | (intrEnQ & hangQ);

endmodule

// File: rtl/host_fw_mailbox.sv
module host_fw_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int TYPE_W      = 8,
  parameter int PAYLOAD_W   = 24,
  parameter int OFS_OWNER   = 0,
  parameter int OFS_DATAIN  = 1,
  parameter int OFS_DATAOUT = 2,
  parameter int OFS_CMD     = 3,
  parameter int OFS_INTR    = 4,
  localparam int DATA_W     = TYPE_W + PAYLOAD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWrData,
  output logic [DATA_W-1:0]    hostRdData,
  input  logic                 ctrlClaimEn,
  input  logic                 ctrlReleaseEn,
  input  logic                 ctrlPostEn,
  input  logic [TYPE_W-1:0]    ctrlPostType,
  input  logic [PAYLOAD_W-1:0] ctrlPostPayload,
  input  logic                 ctrlAckEn,
  input  logic                 ctrlHangEn,
  output logic [TYPE_W-1:0]    ctrlInType,
  output logic [PAYLOAD_W-1:0] ctrlInPayload,
  output logic                 ctrlIrq,
  output logic                 hostIrq
);

  mbox_strobe_t strobe;
  logic [1:0]   ownerState;

  mbox_ctrl #(
    .ADDR_W(ADDR_W), .OFS_OWNER(OFS_OWNER), .OFS_DATAIN(OFS_DATAIN),
    .OFS_CMD(OFS_CMD), .OFS_INTR(OFS_INTR)
  ) ctrl_i (
    .hostWrEn     (hostWrEn),
    .hostAddr     (hostAddr),
    .ownerCode    (hostWrData[1:0]),
    .ownerState   (ownerState),
    .ctrlClaimEn  (ctrlClaimEn),
    .ctrlReleaseEn(ctrlReleaseEn),
    .ctrlPostEn   (ctrlPostEn),
    .ctrlAckEn    (ctrlAckEn),
    .ctrlHangEn   (ctrlHangEn),
    .strobe       (strobe)
  );

  mbox_dp #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .PAYLOAD_W(PAYLOAD_W),
    .OFS_OWNER(OFS_OWNER), .OFS_DATAIN(OFS_DATAIN), .OFS_DATAOUT(OFS_DATAOUT),
    .OFS_CMD(OFS_CMD), .OFS_INTR(OFS_INTR)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .postType   (ctrlPostType),
    .postPayload(ctrlPostPayload),
    .hostRdData (hostRdData),
    .ownerState (ownerState),
    .inType     (ctrlInType),
    .inPayload  (ctrlInPayload),
    .ctrlIrq    (ctrlIrq),
    .hostIrq    (hostIrq)
  );

endmodule

// File: rtl/host_fw_mailbox_chk.sv
module host_fw_mailbox_chk
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int OFS_OWNER = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic              ctrlClaimEn,
  input logic              ctrlReleaseEn,
  input logic              ctrlPostEn,
  input logic              ctrlAckEn,
  input logic              ctrlIrq,
  input logic              hostIrq,
  input logic [1:0]        ownerState
);

  logic hostOwnWr;
  logic hostClaims;
  assign hostOwnWr  = hostWrEn && (hostAddr == ADDR_W'(OFS_OWNER));
  assign hostClaims = hostOwnWr &&
                      (hostWrData[1:0] == OWNER_FW || hostWrData[1:0] == OWNER_SW);

  AST_OWNER_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ownerState != OWNER_BAD); // R2

  AST_CLAIM_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (ownerState != OWNER_NONE && hostOwnWr && hostWrData[1:0] != OWNER_NONE
     && !ctrlReleaseEn) |=> $stable(ownerState)); // R3

  AST_RELEASE_NONE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReleaseEn |=> ownerState == OWNER_NONE); // R4

  AST_CTRL_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlClaimEn && ownerState == OWNER_NONE && !ctrlReleaseEn && !hostClaims)
    |=> ownerState == OWNER_FW); // R5

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ctrlAckEn |=> !ctrlIrq); // R8

  AST_POST_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ctrlPostEn |=> hostIrq); // R9

endmodule

bind host_fw_mailbox host_fw_mailbox_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_OWNER(OFS_OWNER)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .hostWrEn     (hostWrEn),
  .hostAddr     (hostAddr),
  .hostWrData   (hostWrData),
  .ctrlClaimEn  (ctrlClaimEn),
  .ctrlReleaseEn(ctrlReleaseEn),
  .ctrlPostEn   (ctrlPostEn),
  .ctrlAckEn    (ctrlAckEn),
  .ctrlIrq      (ctrlIrq),
  .hostIrq      (hostIrq),
  .ownerState   (ownerState)
);

// File: tb/host_fw_mailbox_tb_top.sv
module host_fw_mailbox_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        ctrlClaimEn = 1'b0;
  logic        ctrlReleaseEn = 1'b0;
  logic        ctrlPostEn = 1'b0;
  logic [7:0]  ctrlPostType = '0;
  logic [23:0] ctrlPostPayload = '0;
  logic        ctrlAckEn = 1'b0;
  logic        ctrlHangEn = 1'b0;
  logic [7:0]  ctrlInType;
  logic [23:0] ctrlInPayload;
  logic        ctrlIrq;
  logic        hostIrq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_fw_mailbox dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .ctrlClaimEn(ctrlClaimEn), .ctrlReleaseEn(ctrlReleaseEn),
    .ctrlPostEn(ctrlPostEn), .ctrlPostType(ctrlPostType),
    .ctrlPostPayload(ctrlPostPayload), .ctrlAckEn(ctrlAckEn),
    .ctrlHangEn(ctrlHangEn), .ctrlInType(ctrlInType),
    .ctrlInPayload(ctrlInPayload), .ctrlIrq(ctrlIrq), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    hostAddr = a;
    #1;
    v = hostRdData;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ctrlClaimEn = 1'b1;
      1: ctrlReleaseEn = 1'b1;
      2: ctrlPostEn = 1'b1;
      3: ctrlAckEn = 1'b1;
      default: ctrlHangEn = 1'b1;
    endcase
    @(negedge clk);
    ctrlClaimEn = 1'b0; ctrlReleaseEn = 1'b0; ctrlPostEn = 1'b0;
    ctrlAckEn = 1'b0; ctrlHangEn = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 hostIrq", {31'h0, hostIrq}, 32'h0);
    check("R1 ctrlIrq", {31'h0, ctrlIrq}, 32'h0);

    // R2/R3/R4/R5 claim matrix: start owner x written code
    for (int s = 0; s < 3; s++) begin
      for (int w = 0; w < 4; w++) begin
        wr(3'd0, 32'h0);
        if (s == 1) pulse(0);
        if (s == 2) wr(3'd0, 32'h2);
        rd(3'd0, v);
        check(s == 1 ? "R5 ctrl claim on free" : "R2 start owner", v, 32'(s));
        wr(3'd0, 32'hFFFF_FFF0 | 32'(w));
        if (w == 0) exp = 0;
        else if (w == 3) exp = 32'(s);
        else if (s == 0) exp = 32'(w);
        else exp = 32'(s);
        rd(3'd0, v);
        if (w == 0) check("R4 host release", v, exp);
        else if (w == 3 || s != 0) check("R3 claim ignored", v, exp);
        else check("R2 claim on free", v, exp);
      end
    end
    // R5 controller claim blocked, then R4 controller release
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h2);
    pulse(0);
    rd(3'd0, v);
    check("R5 ctrl claim blocked", v, 32'h2);
    pulse(1);
    rd(3'd0, v);
    check("R4 ctrl release", v, 32'h0);

    // R6 packing of host-to-controller word
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  t;
      logic [23:0] p;
      t = 8'(i * 37 + 5);
      p = 24'(i * 24'h0B1C3D + 24'h000101);
      wr(3'd1, {t, p});
      rd(3'd1, v);
      check("R6 data-in readback", v, {t, p});
      check("R6 type field", {24'h0, ctrlInType}, {24'h0, t});
      check("R6 payload field", {8'h0, ctrlInPayload}, {8'h0, p});
    end

    // R7/R8 command flag sweep
    for (int k = 0; k < 32; k++) begin
      logic [4:0] f;
      f = 5'(k);
      wr(3'd3, {f, 27'h5A5A5A5 ^ 27'(k)});
      rd(3'd3, v);
      check("R7 cmd masking", v, {f, 27'h0});
      check("R7 ctrlIrq", {31'h0, ctrlIrq}, {31'h0, f[4] & f[0]});
      if (f[0]) begin
        pulse(3);
        rd(3'd3, v);
        check("R8 ack clears bit27", v, {f[4:1], 1'b0, 27'h0});
        check("R8 ctrlIrq low", {31'h0, ctrlIrq}, 32'h0);
      end
    end

    // R9 posting messages
    wr(3'd3, 32'h0);
    for (int i = 0; i < 4; i++) begin
      logic [7:0]  t;
      logic [23:0] p;
      t = (i % 2 == 1) ? 8'h81 : 8'h80;
      p = 24'(i * 24'h012345 + 1);
      @(negedge clk);
      ctrlPostType = t; ctrlPostPayload = p;
      pulse(2);
      rd(3'd2, v);
      check("R9 data-out word", v, {t, p});
      check("R9 hostIrq high", {31'h0, hostIrq}, 32'h1);
      rd(3'd3, v);
      check("R9 sysmgt bit set", v, 32'h2000_0000);
      repeat (2) @(negedge clk);
      check("R9 hostIrq held", {31'h0, hostIrq}, 32'h1);
      wr(3'd3, v & ~32'h2000_0000);
      check("R9 hostIrq cleared", {31'h0, hostIrq}, 32'h0);
      // R11 write to data-out has no effect
      wr(3'd2, ~{t, p});
      rd(3'd2, v);
      check("R11 data-out write ignored", v, {t, p});
    end

    // R10 interrupt status sweep
    for (int en = 0; en < 2; en++) begin
      for (int h = 0; h < 2; h++) begin
        for (int wb = 0; wb < 4; wb++) begin
          wr(3'd4, 32'(en * 8 + 2));
          if (h == 1) pulse(4);
          rd(3'd4, v);
          check("R10 status before", v, 32'(en * 8 + h * 2));
          check("R10 hostIrq before", {31'h0, hostIrq}, 32'(en & h));
          wr(3'd4, 32'((wb / 2) * 8 + (wb % 2) * 2));
          rd(3'd4, v);
          exp = 32'((wb / 2) * 8 + ((h == 1 && wb % 2 == 0) ? 2 : 0));
          check("R10 status after write", v, exp);
          check("R10 hostIrq after", {31'h0, hostIrq}, {31'h0, exp[3] & exp[1]});
        end
      end
    end

    // R11 unmapped addresses
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hDEAD_BEEF);
      rd(3'(a), v);
      check("R11 unmapped read", v, 32'h0);
    end

    summary();
  end

endmodule